// File: doc/BRIEF.md
# LCD Controller Register File

This block is the software-visible configuration and status bank of an LCD controller. A processor writes and reads it over a plain 32-bit bus with a byte address and a single write strobe. Read data is combinational from the addressed register, and writes take effect on the next rising clock edge. The stored configuration goes straight out on dedicated ports to the display datapath. That configuration covers enable, monochrome and active-matrix selection, palette load mode, panel width, panel height and the subpanel word.

The datapath reports three kinds of event back to the block as one-cycle pulses: frame complete, palette loaded and sync error. Each event sets a sticky status flag, and software clears a flag by writing one to its bit. A single interrupt line is formed from the flags for frame complete and palette loaded, each gated by its own enable bit in the control register.

Several registers do not read back exactly what was written. Fixed one-bits are merged into the read value, the active-matrix bit appears at two positions, and panel dimensions are exported as the programmed value plus one.

Top module: `lcd_regbank`

## Requirements
- R1: After reset the outputs are as follows: enable_o, mono_o and tft_o are 0, plm_o is 0, width_o and height_o are 1, subpanel_o is 0 and irq_o is 0. Reads return 0xfe000c34 at 0x00, 0x0000000f at 0x04, 0x00000000 at 0x08, 0xfc000000 at 0x0c, 0x00000000 at 0x10 and 0x00000000 at 0x14.
- R2: A write to offset 0x00 loads the following fields: enable from bit 0, mono from bit 1, the interrupt enables from bits 4:3 (bit 3 gates frame complete, bit 4 gates palette loaded), the active-matrix bit from bit 7 and the palette load mode from bits 21:20. Of the remaining bits, only those under mask 0x01cff300 are kept. Enable, mono, active-matrix and palette mode appear on enable_o, mono_o, tft_o and plm_o.
- R3: A read of offset 0x00 returns the fields of R2 at their bit positions, the active-matrix bit also at bit 23, and the kept bits, all OR-ed with 0xfe000c34.
- R4: A write to offset 0x04 loads bits 9:0 as width minus one and keeps bits 31:10. width_o equals bits 9:0 plus one, and a read returns the kept bits together with width minus one, OR-ed with 0x0000000f.
- R5: A write to offset 0x08 loads bits 9:0 as height minus one and keeps bits 31:10. height_o equals bits 9:0 plus one, and a read returns the written word unchanged.
- R6: A write to offset 0x0c stores all 32 bits, and a read returns them OR-ed with 0xfc000000.
- R7: A write to offset 0x14 stores the data AND 0xa1ffffff. The stored word appears on subpanel_o and is returned by a read.
- R8: Offset 0x10 holds sticky flags: frame complete at bit 0, sync error at bit 2 and palette loaded at bit 6. Each flag is set on the clock edge after its event pulse and stays set until cleared. All other bits read 0.
- R9: Writing a one to flag bit 0, 2 or 6 at offset 0x10 clears that flag, and writing a zero leaves it unchanged. If an event and a clear reach the same flag in the same cycle, the flag stays set.
- R10: irq_o is high exactly when frame complete is set with control bit 3 set, or when palette loaded is set with control bit 4 set. The sync error flag never drives irq_o.
- R11: Only the six exact offsets 0x00, 0x04, 0x08, 0x0c, 0x10 and 0x14 are decoded. Any other address reads 0, and a write to it changes no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address of the register |
| wr_en_i | input | 1 | Write strobe; write taken at the clock edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed register, combinational |
| frame_done_i | input | 1 | Frame complete event pulse |
| palette_done_i | input | 1 | Palette loaded event pulse |
| sync_err_i | input | 1 | Sync error event pulse |
| enable_o | output | 1 | Controller enable |
| mono_o | output | 1 | Monochrome select |
| tft_o | output | 1 | Active-matrix panel select |
| plm_o | output | 2 | Palette load mode |
| width_o | output | 11 | Panel width in pixels |
| height_o | output | 11 | Panel height in lines |
| subpanel_o | output | 32 | Subpanel configuration word |
| irq_o | output | 1 | Interrupt request, level |

## Verification
The assertions assume that wr_en_i, addr_i, wdata_i and the event pulses are stable around the rising edge and free of X once reset is released. They also assume a write is a single-cycle strobe whose data is taken at that edge. The bench drives every input on the falling edge and lowers the strobe after one cycle, so each write lands on exactly one rising edge. The event-versus-clear collision is the only case where a write and an event meet in the same cycle, and the bench creates it on purpose.

// File: rtl/lcd_regbank_pkg.sv
package lcd_regbank_pkg;

  localparam int unsigned REG_CNT = 6;

  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0,
    SEL_TIM0 = 3'd1,
    SEL_TIM1 = 3'd2,
    SEL_TIM2 = 3'd3,
    SEL_STAT = 3'd4,
    SEL_SUBP = 3'd5
  } reg_sel_e;

  localparam logic [31:0] CTRL_KEEP_MASK  = 32'h01cf_f300;
  localparam logic [31:0] CTRL_FIXED_ONES = 32'hfe00_0c34;
  localparam logic [31:0] TIM0_FIXED_ONES = 32'h0000_000f;
  localparam logic [31:0] TIM2_FIXED_ONES = 32'hfc00_0000;
  localparam logic [31:0] SUBP_WMASK      = 32'ha1ff_ffff;

  // status flag index -> bit position in the status word
  localparam int unsigned FLAG_CNT = 3;
  localparam int unsigned FLG_FRAME = 0;
  localparam int unsigned FLG_SYNC  = 1;
  localparam int unsigned FLG_PAL   = 2;

  function automatic int unsigned flag_bitpos(int unsigned idx);
    case (idx)
      FLG_FRAME: return 0;
      FLG_SYNC:  return 2;
      default:   return 6;
    endcase
  endfunction

  typedef struct packed {
    logic        enable;
    logic        mono;
    logic [1:0]  irq_en;
    logic        tft;
    logic [1:0]  plm;
    logic [31:0] keep;
  } ctrl_t;

endpackage

// File: rtl/lcd_addr_decode.sv
module lcd_addr_decode
  import lcd_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [REG_CNT-1:0] sel_o
);
  // registers sit on consecutive 32-bit words from offset 0
  for (genvar g = 0; g < REG_CNT; g++) begin : g_sel
    assign sel_o[g] = (addr_i == ADDR_W'(g * 4));
  end
endmodule

// File: rtl/lcd_ctrl_reg.sv
module lcd_ctrl_reg
  import lcd_regbank_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output ctrl_t             ctrl_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (we_i) begin
      ctrl_q.enable <= wdata_i[0];
      ctrl_q.mono   <= wdata_i[1];
      ctrl_q.irq_en <= wdata_i[4:3];
      ctrl_q.tft    <= wdata_i[7];
      ctrl_q.plm    <= wdata_i[21:20];
      ctrl_q.keep   <= wdata_i[31:0] & CTRL_KEEP_MASK;
    end
  end

  assign ctrl_o = ctrl_q;

  p_keep_masked_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ((ctrl_q.keep & ~CTRL_KEEP_MASK) == '0));

  p_ctrl_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(ctrl_q));
endmodule

// File: rtl/lcd_dim_reg.sv
module lcd_dim_reg #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DIM_W  = 10,
  localparam int unsigned HI_W  = DATA_W - DIM_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DIM_W-1:0]  dim_m1_o,
  output logic [HI_W-1:0]   hi_o,
  output logic [DIM_W:0]    dim_o
);
  logic [DIM_W-1:0] dim_m1_q;
  logic [HI_W-1:0]  hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dim_m1_q <= '0;
      hi_q     <= '0;
    end else if (we_i) begin
      dim_m1_q <= wdata_i[DIM_W-1:0];
      hi_q     <= wdata_i[DATA_W-1:DIM_W];
    end
  end

  assign dim_m1_o = dim_m1_q;
  assign hi_o     = hi_q;
  assign dim_o    = (DIM_W+1)'(dim_m1_q) + (DIM_W+1)'(1);

  p_dim_plus_one_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (dim_o == (DIM_W+1)'($past(wdata_i[DIM_W-1:0])) + (DIM_W+1)'(1)));

  p_dim_nonzero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dim_o != '0);
endmodule

// File: rtl/lcd_status_flags.sv
module lcd_status_flags #(
  parameter int unsigned FLAG_N = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAG_N-1:0] evt_i,
  input  logic              clr_we_i,
  input  logic [FLAG_N-1:0] clr_bits_i,
  output logic [FLAG_N-1:0] flags_o
);
  logic [FLAG_N-1:0] flags_q;

  for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flags_q[g] <= 1'b0;
      end else if (evt_i[g]) begin
        flags_q[g] <= 1'b1;  // event wins over a same-cycle clear
      end else if (clr_we_i && clr_bits_i[g]) begin
        flags_q[g] <= 1'b0;
      end
    end

    p_evt_sets_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[g] |=> flags_q[g]);

    p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_q[g] && !(clr_we_i && clr_bits_i[g])) |=> flags_q[g]);

    p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_we_i && clr_bits_i[g] && !evt_i[g]) |=> !flags_q[g]);

    p_no_spurious_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!flags_q[g] && !evt_i[g]) |=> !flags_q[g]);
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/lcd_regbank.sv
module lcd_regbank
  import lcd_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DIM_W  = 10,
  localparam int unsigned HI_W  = DATA_W - DIM_W,
  localparam int unsigned DIM_CNT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              frame_done_i,
  input  logic              palette_done_i,
  input  logic              sync_err_i,
  output logic              enable_o,
  output logic              mono_o,
  output logic              tft_o,
  output logic [1:0]        plm_o,
  output logic [DIM_W:0]    width_o,
  output logic [DIM_W:0]    height_o,
  output logic [DATA_W-1:0] subpanel_o,
  output logic              irq_o
);
  logic [REG_CNT-1:0] sel;
  ctrl_t              ctrl;
  logic [DIM_W-1:0]   dim_m1 [DIM_CNT];
  logic [HI_W-1:0]    dim_hi [DIM_CNT];
  logic [DIM_W:0]     dim    [DIM_CNT];
  logic [DATA_W-1:0]  tim2_q;
  logic [DATA_W-1:0]  subp_q;
  logic [FLAG_CNT-1:0] flags;
  logic [FLAG_CNT-1:0] evt;
  logic [FLAG_CNT-1:0] clr_bits;
  logic               any_sel;

  lcd_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  assign any_sel = |sel;

  lcd_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i && sel[int'(SEL_CTRL)]),
    .wdata_i (wdata_i),
    .ctrl_o  (ctrl)
  );

  // timing0 holds width, timing1 holds height
  for (genvar g = 0; g < DIM_CNT; g++) begin : g_dim
    lcd_dim_reg #(.DATA_W(DATA_W), .DIM_W(DIM_W)) u_dim (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (wr_en_i && sel[int'(SEL_TIM0) + g]),
      .wdata_i  (wdata_i),
      .dim_m1_o (dim_m1[g]),
      .hi_o     (dim_hi[g]),
      .dim_o    (dim[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tim2_q <= '0;
      subp_q <= '0;
    end else if (wr_en_i) begin
      if (sel[int'(SEL_TIM2)]) tim2_q <= wdata_i;
      if (sel[int'(SEL_SUBP)]) subp_q <= wdata_i & SUBP_WMASK;
    end
  end

  assign evt[FLG_FRAME] = frame_done_i;
  assign evt[FLG_SYNC]  = sync_err_i;
  assign evt[FLG_PAL]   = palette_done_i;

  for (genvar g = 0; g < FLAG_CNT; g++) begin : g_clr
    assign clr_bits[g] = wdata_i[flag_bitpos(g)];
  end

  lcd_status_flags #(.FLAG_N(FLAG_CNT)) u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt),
    .clr_we_i   (wr_en_i && sel[int'(SEL_STAT)]),
    .clr_bits_i (clr_bits),
    .flags_o    (flags)
  );

  assign irq_o = (flags[FLG_FRAME] && ctrl.irq_en[0]) ||
                 (flags[FLG_PAL]   && ctrl.irq_en[1]);

  always_comb begin
    rdata_o = '0;
    if (sel[int'(SEL_CTRL)]) begin
      rdata_o          = CTRL_FIXED_ONES | ctrl.keep;
      rdata_o[0]       = rdata_o[0] | ctrl.enable;
      rdata_o[1]       = rdata_o[1] | ctrl.mono;
      rdata_o[4:3]     = rdata_o[4:3] | ctrl.irq_en;
      rdata_o[7]       = rdata_o[7] | ctrl.tft;
      rdata_o[21:20]   = rdata_o[21:20] | ctrl.plm;
      rdata_o[23]      = rdata_o[23] | ctrl.tft;
    end
    if (sel[int'(SEL_TIM0)]) rdata_o = {dim_hi[0], dim_m1[0]} | TIM0_FIXED_ONES;
    if (sel[int'(SEL_TIM1)]) rdata_o = {dim_hi[1], dim_m1[1]};
    if (sel[int'(SEL_TIM2)]) rdata_o = tim2_q | TIM2_FIXED_ONES;
    if (sel[int'(SEL_STAT)]) begin
      for (int i = 0; i < FLAG_CNT; i++) rdata_o[flag_bitpos(i)] = flags[i];
    end
    if (sel[int'(SEL_SUBP)]) rdata_o = subp_q;
  end

  assign enable_o   = ctrl.enable;
  assign mono_o     = ctrl.mono;
  assign tft_o      = ctrl.tft;
  assign plm_o      = ctrl.plm;
  assign width_o    = dim[0];
  assign height_o   = dim[1];
  assign subpanel_o = subp_q;

  p_sel_onehot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel));

  p_unmapped_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !any_sel) |=> ($stable(ctrl) && $stable(tim2_q) && $stable(subp_q)
                               && $stable(width_o) && $stable(height_o)));

  p_unmapped_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_sel |-> (rdata_o == '0));

  p_irq_gated_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.irq_en == 2'b00) |-> !irq_o);

  p_sync_no_irq_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flags[FLG_FRAME] && !flags[FLG_PAL]) |-> !irq_o);

  p_subp_mask_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (subpanel_o & ~SUBP_WMASK) == '0);

  p_ctrl_fixed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel[int'(SEL_CTRL)] |-> ((rdata_o & CTRL_FIXED_ONES) == CTRL_FIXED_ONES));

  p_tft_mirror_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel[int'(SEL_CTRL)] && tft_o) |-> (rdata_o[7] && rdata_o[23]));
endmodule

// File: tb/lcd_regbank_tb.sv
module lcd_regbank_tb;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        frame_done = 1'b0, palette_done = 1'b0, sync_err = 1'b0;
  logic        enable, mono, tft, irq;
  logic [1:0]  plm;
  logic [10:0] width, height;
  logic [31:0] subpanel;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  lcd_regbank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata),
    .rdata_o(rdata), .frame_done_i(frame_done), .palette_done_i(palette_done),
    .sync_err_i(sync_err), .enable_o(enable), .mono_o(mono), .tft_o(tft),
    .plm_o(plm), .width_o(width), .height_o(height), .subpanel_o(subpanel),
    .irq_o(irq)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(string req, logic [7:0] a, logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #2;
    check(req, $sformatf("read 0x%02h", a), rdata, exp);
  endtask

  task automatic pulse(logic f, logic p, logic s);
    @(negedge clk);
    frame_done = f; palette_done = p; sync_err = s;
    @(negedge clk);
    frame_done = 1'b0; palette_done = 1'b0; sync_err = 1'b0;
  endtask

  task automatic t_reset;
    rd_check("R1", 8'h00, 32'hfe00_0c34);
    rd_check("R1", 8'h04, 32'h0000_000f);
    rd_check("R1", 8'h08, 32'h0000_0000);
    rd_check("R1", 8'h0c, 32'hfc00_0000);
    rd_check("R1", 8'h10, 32'h0000_0000);
    rd_check("R1", 8'h14, 32'h0000_0000);
    check("R1", "outputs", {enable, mono, tft, plm, irq}, '0);
    check("R1", "width", 32'(width), 32'd1);
    check("R1", "height", 32'(height), 32'd1);
    check("R1", "subpanel", subpanel, 32'h0);
  endtask

  task automatic t_ctrl;
    wr(8'h00, 32'h0030_0083);
    check("R2", "enable/mono/tft", {enable, mono, tft}, 3'b111);
    check("R2", "plm", 32'(plm), 32'd3);
    rd_check("R3", 8'h00, 32'hfeb0_0cb7);
    wr(8'h00, 32'hffff_ffff);
    rd_check("R3", 8'h00, 32'hffff_ffbf);
    wr(8'h00, 32'h0010_0000);
    check("R2", "plm=1 others clear", {enable, mono, tft, plm}, 5'b00001);
    rd_check("R2", 8'h00, 32'hfe10_0c34);
    wr(8'h00, 32'h0000_0000);
  endtask

  task automatic t_timing;
    wr(8'h04, 32'habcd_e130);
    check("R4", "width", 32'(width), 32'd305);
    rd_check("R4", 8'h04, 32'habcd_e13f);
    wr(8'h04, 32'h0000_0000);
    check("R4", "width min", 32'(width), 32'd1);
    wr(8'h08, 32'h5555_51df);
    check("R5", "height", 32'(height), 32'd480);
    rd_check("R5", 8'h08, 32'h5555_51df);
    wr(8'h08, 32'h0000_03ff);
    check("R5", "height max", 32'(height), 32'd1024);
    wr(8'h0c, 32'h0000_1234);
    rd_check("R6", 8'h0c, 32'hfc00_1234);
    wr(8'h14, 32'hffff_ffff);
    check("R7", "subpanel port", subpanel, 32'ha1ff_ffff);
    rd_check("R7", 8'h14, 32'ha1ff_ffff);
  endtask

  task automatic t_status;
    pulse(1'b1, 1'b0, 1'b0);
    rd_check("R8", 8'h10, 32'h0000_0001);
    check("R10", "irq masked", 32'(irq), 32'd0);
    pulse(1'b0, 1'b1, 1'b0);
    rd_check("R8", 8'h10, 32'h0000_0041);
    pulse(1'b0, 1'b0, 1'b1);
    rd_check("R8", 8'h10, 32'h0000_0045);
    wr(8'h10, 32'h0000_0000);
    rd_check("R9", 8'h10, 32'h0000_0045);
    wr(8'h00, 32'h0000_0008);
    check("R10", "irq frame", 32'(irq), 32'd1);
    wr(8'h10, 32'h0000_0001);
    rd_check("R9", 8'h10, 32'h0000_0044);
    check("R10", "irq after frame clear", 32'(irq), 32'd0);
    wr(8'h00, 32'h0000_0010);
    check("R10", "irq palette", 32'(irq), 32'd1);
    wr(8'h10, 32'h0000_0040);
    check("R10", "irq after palette clear", 32'(irq), 32'd0);
    wr(8'h00, 32'h0000_0018);
    check("R10", "sync alone no irq", 32'(irq), 32'd0);
    wr(8'h10, 32'h0000_0004);
    rd_check("R9", 8'h10, 32'h0000_0000);
    // event and clear in the same cycle: set wins
    @(negedge clk);
    frame_done = 1'b1; addr = 8'h10; wdata = 32'h1; wr_en = 1'b1;
    @(negedge clk);
    frame_done = 1'b0; wr_en = 1'b0;
    rd_check("R9", 8'h10, 32'h0000_0001);
    check("R10", "irq after collision", 32'(irq), 32'd1);
    wr(8'h10, 32'h0000_0001);
    wr(8'h00, 32'h0000_0000);
  endtask

  task automatic t_unmapped;
    wr(8'h18, 32'hffff_ffff);
    wr(8'h02, 32'hffff_ffff);
    wr(8'hfc, 32'hffff_ffff);
    rd_check("R11", 8'h18, 32'h0);
    rd_check("R11", 8'h02, 32'h0);
    rd_check("R11", 8'h00, 32'hfe00_0c34);
    rd_check("R11", 8'h08, 32'h0000_03ff);
    rd_check("R11", 8'h0c, 32'hfc00_1234);
    rd_check("R11", 8'h10, 32'h0);
    check("R11", "width kept", 32'(width), 32'd1);
    check("R11", "subpanel kept", subpanel, 32'ha1ff_ffff);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl();
    t_timing();
    t_status();
    t_unmapped();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule